// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into its final page descriptor by reading translation tables from memory. A walk begins at one of two root pointers: the supervisor pointer when the request's supervisor flag is set, the user pointer otherwise. From there it descends through a root table, a pointer table and a page table. A page-table entry may instead point indirectly at the real descriptor, and the walker then makes one more read. All table traffic goes through a single 32-bit memory port with a valid/ready handshake and an error return.

While it walks, the block keeps the table flags up to date. A root or pointer entry whose used flag is clear is rewritten with that flag set. At the leaf, the write-protect flags gathered from the upper levels are merged into the descriptor, and the used and modified flags are brought up to date for the access type. The leaf is rewritten only when one of those flags actually changes. When the walk ends, the block returns the resulting descriptor with an invalid flag and pulses done for one cycle.

The engine handles one request at a time. The page size, 4 KB or 8 KB, is a static input. It sets how many address bits index the page table.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk is at {root[31:9], addr[31:25], 2'b00}, where root is `sup_root` when `req_super`=1 and `usr_root` otherwise.
- R2: The pointer-level read is at {rootdesc[31:9], addr[24:18], 2'b00}, where rootdesc is the root-level entry.
- R3: The page-level read is at {ptrdesc[31:8], addr[17:12], 2'b00} when `page_8k`=0 and at {ptrdesc[31:7], addr[17:13], 2'b00} when `page_8k`=1.
- R4: A root or pointer entry with bit 1 clear ends the walk. The result is 0 with `res_invalid`=1, and nothing further is read or written.
- R5: A root or pointer entry that is valid but has used (bit 3) clear is written back to its own address with bit 3 set, before the next level is read. When bit 3 is already set, no write is made.
- R6: A page-level entry with bits [1:0]=2'b10 is indirect. The walker reads the real descriptor from {entry[31:2], 2'b00}, and any leaf write-back goes to that address.
- R7: A leaf descriptor with bit 0 clear is returned unchanged, with `res_invalid`=1 and no write-back.
- R8: For a resident leaf (bit 0 set), bit 2 (write-protect) of the returned value is the OR of bit 2 of the root entry, the pointer entry and the leaf.
- R9: A resident leaf has bit 3 set on a read and on a protected write, and bits 3 and 4 set on an unprotected write. It is written back, with the returned value, only when this changes it. `res_invalid` is then 0.
- R10: A memory error on any access of the walk ends it with result 0 and `res_invalid`=1. A write that returns an error leaves that word unchanged.
- R11: After reset the block is idle with `req_ready`=1. A request is taken only while `req_ready`=1. `busy` stays high until the single-cycle `done` pulse, and requests offered while busy are ignored.
- R12: Once `mem_valid` is raised, it stays high with stable address, direction and write data until `mem_ready` is seen. `mem_valid` is never raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | 32 | Logical address to translate |
| req_super | input | 1 | Supervisor access (selects `sup_root`) |
| req_write | input | 1 | Access is a write |
| page_8k | input | 1 | 1: 8 KB pages, 0: 4 KB pages (static) |
| sup_root | input | 32 | Supervisor root table pointer |
| usr_root | input | 32 | User root table pointer |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| res_desc | output | 32 | Resulting page descriptor |
| res_invalid | output | 1 | Result is not a resident translation |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory access accepted and completed |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_err | input | 1 | Memory access failed, valid with `mem_ready` |

## Verification
The assertions take three things for granted about the inputs: the memory side answers each access only while `mem_valid` is high, `page_8k` does not change during a walk, and a request's write flag is the one captured at acceptance. The bench's memory model answers after a random zero to two cycle wait and only while the walker holds its request. It changes the page size and the root pointers only between walks, with the engine idle. Requests made while busy exercise the ignore path and never alter a walk that is already running.

// File: rtl/pt_walk_pkg.sv
// Package: shared constants and state type for the page table walker.
// Assumes 32-bit descriptors whose low flag bits carry fixed meanings.
package pt_walk_pkg;
    localparam int unsigned DESC_W    = 32;
    localparam int unsigned ADDR_W    = 32;
    // Descriptor flag bit positions
    localparam int unsigned F_RESIDENT = 0;
    localparam int unsigned F_VALID    = 1;
    localparam int unsigned F_WPROT    = 2;
    localparam int unsigned F_USED     = 3;
    localparam int unsigned F_MOD      = 4;
    // Table geometry
    localparam int unsigned UPPER_BASE_LSB = 9;   // root and pointer table base
    localparam int unsigned PAGE4_BASE_LSB = 8;   // page table base, 4 KB pages
    localparam int unsigned PAGE8_BASE_LSB = 7;   // page table base, 8 KB pages
    localparam int unsigned ROOT_IDX_LSB   = 25;
    localparam int unsigned PTR_IDX_LSB    = 18;
    localparam int unsigned PAGE4_IDX_LSB  = 12;
    localparam int unsigned PAGE8_IDX_LSB  = 13;
    localparam int unsigned PTR_IDX_W      = ROOT_IDX_LSB - PTR_IDX_LSB;
    localparam int unsigned ROOT_IDX_W     = ADDR_W - ROOT_IDX_LSB;
    localparam int unsigned PAGE4_IDX_W    = PTR_IDX_LSB - PAGE4_IDX_LSB;
    localparam int unsigned PAGE8_IDX_W    = PTR_IDX_LSB - PAGE8_IDX_LSB;
    localparam logic [1:0]  KIND_INDIRECT  = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROOT_RD,
        ST_ROOT_WB,
        ST_PTR_RD,
        ST_PTR_WB,
        ST_PAGE_RD,
        ST_IND_RD,
        ST_PAGE_WB,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/pt_addr_gen.sv
// Module: forms the root, pointer and page descriptor addresses.
// Assumes word-aligned descriptors; the page index width follows page_8k.
module pt_addr_gen
    import pt_walk_pkg::*;
(
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [DESC_W-1:0] root_ptr,
    input  logic [DESC_W-1:0] root_desc,
    input  logic [DESC_W-1:0] ptr_desc,
    input  logic              page_8k,
    output logic [ADDR_W-1:0] root_ea,
    output logic [ADDR_W-1:0] ptr_ea,
    output logic [ADDR_W-1:0] page_ea
);
    logic [ADDR_W-1:0] page4_ea;
    logic [ADDR_W-1:0] page8_ea;

    // Upper-level addresses: table base joined to the address index
    always_comb begin
        root_ea = {root_ptr[DESC_W-1:UPPER_BASE_LSB],
                   vaddr[ADDR_W-1:ROOT_IDX_LSB], 2'b00};
        ptr_ea  = {root_desc[DESC_W-1:UPPER_BASE_LSB],
                   vaddr[ROOT_IDX_LSB-1:PTR_IDX_LSB], 2'b00};
    end

    // Page-level address candidates, one for each page size
    always_comb begin
        page4_ea = {ptr_desc[DESC_W-1:PAGE4_BASE_LSB],
                    vaddr[PTR_IDX_LSB-1:PAGE4_IDX_LSB], 2'b00};
        page8_ea = {ptr_desc[DESC_W-1:PAGE8_BASE_LSB],
                    vaddr[PTR_IDX_LSB-1:PAGE8_IDX_LSB], 2'b00};
    end

    // Select the page-level address for the configured page size
    always_comb begin
        page_ea = page_8k ? page8_ea : page4_ea;
    end
endmodule

// File: rtl/pt_flag_update.sv
// Module: merges gathered write-protect into a resident leaf and sets the
// used and modified flags for the access type. Flags a needed write-back.
// Assumes the caller uses the result only for resident leaves.
module pt_flag_update
    import pt_walk_pkg::*;
(
    input  logic [DESC_W-1:0] leaf_in,
    input  logic              wp_acc,
    input  logic              is_write,
    output logic [DESC_W-1:0] leaf_out,
    output logic              need_wb
);
    logic [DESC_W-1:0] merged;

    // Fold the upper-level protection into the leaf
    always_comb begin
        merged           = leaf_in;
        merged[F_WPROT]  = leaf_in[F_WPROT] | wp_acc;
    end

    // Set the access flags and detect a change
    always_comb begin
        leaf_out          = merged;
        leaf_out[F_USED]  = 1'b1;
        if (is_write && !merged[F_WPROT]) begin
            leaf_out[F_MOD] = 1'b1;
        end
        need_wb = (leaf_out != merged);
    end
endmodule

// File: rtl/pt_walker.sv
// Module: three-level table walker with indirect leaves and flag write-back.
// Assumes one outstanding request, page_8k and root pointers stable during a
// walk, and a memory port that answers only while mem_valid is high.
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_super,
    input  logic              req_write,
    input  logic              page_8k,
    input  logic [DESC_W-1:0] sup_root,
    input  logic [DESC_W-1:0] usr_root,
    output logic              busy,
    output logic              done,
    output logic [DESC_W-1:0] res_desc,
    output logic              res_invalid,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DESC_W-1:0] mem_rdata,
    input  logic              mem_err
);
    walk_state_e       state_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic              super_q;
    logic              write_q;
    logic [DESC_W-1:0] root_desc_q;
    logic [DESC_W-1:0] ptr_desc_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [DESC_W-1:0] wdata_q;
    logic              wp_q;
    logic [DESC_W-1:0] res_desc_q;
    logic              res_inv_q;

    logic [ADDR_W-1:0] vaddr_sel;
    logic [DESC_W-1:0] root_sel;
    logic [DESC_W-1:0] root_desc_sel;
    logic [DESC_W-1:0] ptr_desc_sel;
    logic [ADDR_W-1:0] root_ea;
    logic [ADDR_W-1:0] ptr_ea;
    logic [ADDR_W-1:0] page_ea;
    logic [DESC_W-1:0] leaf_upd;
    logic              leaf_need_wb;
    logic              xfer;
    logic              is_rd_state;
    logic              is_wb_state;
    logic              accept;

    // Address sources: live request while idle, fresh read data at each level
    always_comb begin
        vaddr_sel     = (state_q == ST_IDLE) ? req_addr : vaddr_q;
        root_sel      = req_super ? sup_root : usr_root;
        root_desc_sel = (state_q == ST_ROOT_RD) ? mem_rdata : root_desc_q;
        ptr_desc_sel  = (state_q == ST_PTR_RD)  ? mem_rdata : ptr_desc_q;
    end

    pt_addr_gen i_addr_gen (
        .vaddr     (vaddr_sel),
        .root_ptr  (root_sel),
        .root_desc (root_desc_sel),
        .ptr_desc  (ptr_desc_sel),
        .page_8k   (page_8k),
        .root_ea   (root_ea),
        .ptr_ea    (ptr_ea),
        .page_ea   (page_ea)
    );

    pt_flag_update i_flag_update (
        .leaf_in   (mem_rdata),
        .wp_acc    (wp_q),
        .is_write  (write_q),
        .leaf_out  (leaf_upd),
        .need_wb   (leaf_need_wb)
    );

    // Decode the memory-facing state groups
    always_comb begin
        is_rd_state = (state_q == ST_ROOT_RD) || (state_q == ST_PTR_RD) ||
                      (state_q == ST_PAGE_RD) || (state_q == ST_IND_RD);
        is_wb_state = (state_q == ST_ROOT_WB) || (state_q == ST_PTR_WB) ||
                      (state_q == ST_PAGE_WB);
        xfer        = (is_rd_state || is_wb_state) && mem_ready;
        accept      = (state_q == ST_IDLE) && req_valid;
    end

    // Drive the outward ports from registered state
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        mem_valid   = is_rd_state || is_wb_state;
        mem_we      = is_wb_state;
        mem_addr    = cur_addr_q;
        mem_wdata   = wdata_q;
        res_desc    = res_desc_q;
        res_invalid = res_inv_q;
    end

    // Walk sequencer: level reads, flag write-backs and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            vaddr_q     <= '0;
            super_q     <= 1'b0;
            write_q     <= 1'b0;
            root_desc_q <= '0;
            ptr_desc_q  <= '0;
            cur_addr_q  <= '0;
            wdata_q     <= '0;
            wp_q        <= 1'b0;
            res_desc_q  <= '0;
            res_inv_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        vaddr_q    <= req_addr;
                        super_q    <= req_super;
                        write_q    <= req_write;
                        wp_q       <= 1'b0;
                        cur_addr_q <= root_ea;
                        state_q    <= ST_ROOT_RD;
                    end
                end
                ST_ROOT_RD: begin
                    if (xfer) begin
                        if (mem_err || !mem_rdata[F_VALID]) begin
                            res_desc_q <= '0;
                            res_inv_q  <= 1'b1;
                            state_q    <= ST_DONE;
                        end else begin
                            root_desc_q <= mem_rdata;
                            wp_q        <= mem_rdata[F_WPROT];
                            if (!mem_rdata[F_USED]) begin
                                wdata_q         <= mem_rdata | (DESC_W'(1) << F_USED);
                                state_q         <= ST_ROOT_WB;
                            end else begin
                                cur_addr_q <= ptr_ea;
                                state_q    <= ST_PTR_RD;
                            end
                        end
                    end
                end
                ST_ROOT_WB: begin
                    if (xfer) begin
                        if (mem_err) begin
                            res_desc_q <= '0;
                            res_inv_q  <= 1'b1;
                            state_q    <= ST_DONE;
                        end else begin
                            cur_addr_q <= ptr_ea;
                            state_q    <= ST_PTR_RD;
                        end
                    end
                end
                ST_PTR_RD: begin
                    if (xfer) begin
                        if (mem_err || !mem_rdata[F_VALID]) begin
                            res_desc_q <= '0;
                            res_inv_q  <= 1'b1;
                            state_q    <= ST_DONE;
                        end else begin
                            ptr_desc_q <= mem_rdata;
                            wp_q       <= wp_q | mem_rdata[F_WPROT];
                            if (!mem_rdata[F_USED]) begin
                                wdata_q <= mem_rdata | (DESC_W'(1) << F_USED);
                                state_q <= ST_PTR_WB;
                            end else begin
                                cur_addr_q <= page_ea;
                                state_q    <= ST_PAGE_RD;
                            end
                        end
                    end
                end
                ST_PTR_WB: begin
                    if (xfer) begin
                        if (mem_err) begin
                            res_desc_q <= '0;
                            res_inv_q  <= 1'b1;
                            state_q    <= ST_DONE;
                        end else begin
                            cur_addr_q <= page_ea;
                            state_q    <= ST_PAGE_RD;
                        end
                    end
                end
                ST_PAGE_RD, ST_IND_RD: begin
                    if (xfer) begin
                        if (mem_err) begin
                            res_desc_q <= '0;
                            res_inv_q  <= 1'b1;
                            state_q    <= ST_DONE;
                        end else if ((state_q == ST_PAGE_RD) &&
                                     (mem_rdata[1:0] == KIND_INDIRECT)) begin
                            cur_addr_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
                            state_q    <= ST_IND_RD;
                        end else if (!mem_rdata[F_RESIDENT]) begin
                            res_desc_q <= mem_rdata;
                            res_inv_q  <= 1'b1;
                            state_q    <= ST_DONE;
                        end else if (leaf_need_wb) begin
                            wdata_q <= leaf_upd;
                            state_q <= ST_PAGE_WB;
                        end else begin
                            res_desc_q <= leaf_upd;
                            res_inv_q  <= 1'b0;
                            state_q    <= ST_DONE;
                        end
                    end
                end
                ST_PAGE_WB: begin
                    if (xfer) begin
                        if (mem_err) begin
                            res_desc_q <= '0;
                            res_inv_q  <= 1'b1;
                        end else begin
                            res_desc_q <= wdata_q;
                            res_inv_q  <= 1'b0;
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Module: protocol and result checker bound to the page table walker.
// Assumes mem_ready is answered only while mem_valid is high.
module pt_walker_chk
    import pt_walk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              busy,
    input logic              done,
    input logic [DESC_W-1:0] res_desc,
    input logic              res_invalid,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DESC_W-1:0] mem_wdata,
    input logic              mem_ready
);
    logic wr_seen_q;

    // Remember the write flag of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            wr_seen_q <= req_write;
        end
    end

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_we) && $stable(mem_wdata));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy && !req_ready);

    // R5
    wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[F_USED]);

    // R9
    leaf_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_invalid |-> res_desc[F_USED] && res_desc[F_RESIDENT]);

    // R9
    leaf_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_invalid && wr_seen_q && !res_desc[F_WPROT] |-> res_desc[F_MOD]);
endmodule

bind pt_walker pt_walker_chk i_walker_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .busy        (busy),
    .done        (done),
    .res_desc    (res_desc),
    .res_invalid (res_invalid),
    .mem_valid   (mem_valid),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready)
);

// File: tb/test_pt_walker.sv
// Bench: randomized near-exhaustive sweep of table layouts, flags, page sizes,
// access types and injected memory errors, checked against a reference walk.
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_super = 1'b0;
    logic        req_write = 1'b0;
    logic        page_8k = 1'b0;
    logic [31:0] sup_root = 32'h0010_0000;
    logic [31:0] usr_root = 32'h0010_8000;
    logic        busy, done, res_invalid;
    logic [31:0] res_desc;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] mem     [logic [31:0]];
    logic [31:0] ref_mem [logic [31:0]];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          lat = 0;

    logic [31:0] got_addr [$];
    logic        got_we   [$];
    logic [31:0] got_data [$];
    logic [31:0] exp_addr [$];
    logic        exp_we   [$];
    logic [31:0] exp_data [$];
    string       exp_tag  [$];

    logic [31:0] lcg = 32'h1234_5678;

    pt_walker i_pt_walker (.*);

    always #4 clk = ~clk;  // 125 MHz

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %08h expected %08h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg ^ (lcg >> 15);
    endfunction

    // Memory responder: random wait, error injection, access log
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          wait_cnt = 0;
    always @(negedge clk) begin
        cycles++;
        mem_ready = 1'b0;
        mem_err   = 1'b0;
        if (mem_valid) begin
            if (!pend) begin
                pend      = 1'b1;
                pend_addr = mem_addr;
                wait_cnt  = lat;
            end else begin
                chk(mem_addr == pend_addr, "R12", "held address", mem_addr, pend_addr);
            end
            if (wait_cnt == 0) begin
                mem_ready = 1'b1;
                pend      = 1'b0;
                mem_err   = (mem_addr == err_addr);
                got_addr.push_back(mem_addr);
                got_we.push_back(mem_we);
                got_data.push_back(mem_we ? mem_wdata : 32'h0);
                if (mem_we) begin
                    if (!mem_err) mem[mem_addr] = mem_wdata;
                    mem_rdata = 32'h0;
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                end
            end else begin
                wait_cnt--;
            end
        end else begin
            pend = 1'b0;
        end
    end

    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction

    // Record an expected access; returns 1 if it hits the injected error
    function automatic bit ref_acc(input logic [31:0] a, input logic we,
                                   input logic [31:0] d, input string tag);
        exp_addr.push_back(a);
        exp_we.push_back(we);
        exp_data.push_back(we ? d : 32'h0);
        exp_tag.push_back(tag);
        if (we && a != err_addr) ref_mem[a] = d;
        return a == err_addr;
    endfunction

    // Reference walk computed from the requirements
    task automatic ref_walk(input logic [31:0] va, input logic s, input logic w,
                            input logic p8, output logic [31:0] res,
                            output logic inv, output string tag);
        logic [31:0] rp, ra, d, pa, pd, ga, g, m, u;
        logic wp;
        rp = s ? sup_root : usr_root;
        ra = {rp[31:9], va[31:25], 2'b00};
        res = 32'h0; inv = 1'b1;
        if (ref_acc(ra, 1'b0, 0, "R1")) begin tag = "R10"; return; end
        d = ref_rd(ra);
        if (!d[1]) begin tag = "R4"; return; end
        wp = d[2];
        if (!d[3]) begin
            d = d | 32'h8;
            if (ref_acc(ra, 1'b1, d, "R5")) begin tag = "R10"; return; end
        end
        pa = {d[31:9], va[24:18], 2'b00};
        if (ref_acc(pa, 1'b0, 0, "R2")) begin tag = "R10"; return; end
        pd = ref_rd(pa);
        if (!pd[1]) begin tag = "R4"; return; end
        wp = wp | pd[2];
        if (!pd[3]) begin
            pd = pd | 32'h8;
            if (ref_acc(pa, 1'b1, pd, "R5")) begin tag = "R10"; return; end
        end
        ga = p8 ? {pd[31:7], va[17:13], 2'b00} : {pd[31:8], va[17:12], 2'b00};
        if (ref_acc(ga, 1'b0, 0, "R3")) begin tag = "R10"; return; end
        g = ref_rd(ga);
        tag = "R9";
        if (g[1:0] == 2'b10) begin
            ga = {g[31:2], 2'b00};
            if (ref_acc(ga, 1'b0, 0, "R6")) begin tag = "R10"; return; end
            g = ref_rd(ga);
            tag = "R6";
        end
        if (!g[0]) begin res = g; inv = 1'b1; tag = "R7"; return; end
        m = g | {29'h0, wp, 2'b00};
        if (wp) tag = "R8";
        u = m | 32'h8;
        if (w && !m[2]) u = u | 32'h10;
        if (u != m) begin
            if (ref_acc(ga, 1'b1, u, "R9")) begin res = 32'h0; inv = 1'b1; tag = "R10"; return; end
        end
        res = u; inv = 1'b0;
    endtask

    // Drive one request and wait for its completion pulse
    task automatic run_walk(input logic [31:0] va, input logic s, input logic w,
                            output logic [31:0] r, output logic inv);
        int guard;
        @(negedge clk);
        req_addr = va; req_super = s; req_write = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (!done) chk(1'b0, "R11", "done timeout", 32'h0, 32'h1);
        r = res_desc; inv = res_invalid;
    endtask

    task automatic compare_log(input string ctx_tag);
        chk(got_addr.size() == exp_addr.size(), ctx_tag, "access count",
            got_addr.size(), exp_addr.size());
        for (int i = 0; i < exp_addr.size() && i < got_addr.size(); i++) begin
            chk(got_addr[i] == exp_addr[i], exp_tag[i], "access address", got_addr[i], exp_addr[i]);
            chk(got_we[i] == exp_we[i], exp_tag[i], "access direction", 32'(got_we[i]), 32'(exp_we[i]));
            chk(got_data[i] == exp_data[i], exp_tag[i], "write data", got_data[i], exp_data[i]);
        end
    endtask

    task automatic clear_logs();
        got_addr.delete(); got_we.delete(); got_data.delete();
        exp_addr.delete(); exp_we.delete(); exp_data.delete(); exp_tag.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cycles > 190000);
        n_fail++;
        $display("FAIL R11 watchdog expired: got %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r, er, va, rootd, ptrd, leaf, ra, pa, ga, ia, rp;
        logic        inv, einv, s, w;
        string       tag;
        int          kind, esel;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(busy == 1'b0, "R11", "busy after reset", 32'(busy), 32'h0);
        chk(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'h1);
        chk(done == 1'b0, "R11", "done after reset", 32'(done), 32'h0);
        chk(mem_valid == 1'b0, "R12", "idle memory request", 32'(mem_valid), 32'h0);

        for (int it = 0; it < 3000; it++) begin
            clear_logs();
            mem.delete(); ref_mem.delete();
            lat      = int'(next_rand() % 3);
            page_8k  = next_rand() > 32'h8000_0000;
            sup_root = 32'h0010_0000 | (next_rand() & 32'h1FF);
            usr_root = 32'h0010_4000 | (next_rand() & 32'h1FF);
            va = next_rand();
            s  = va[3];
            w  = next_rand() > 32'h8000_0000;
            rp = s ? sup_root : usr_root;
            ra = {rp[31:9], va[31:25], 2'b00};
            rootd = 32'h0020_0000 | (next_rand() & 32'h1F0) | (next_rand() & 32'hD);
            if ((next_rand() & 32'h7) != 0) rootd[1] = 1'b1;
            pa = {rootd[31:9], va[24:18], 2'b00};
            ptrd = 32'h0030_0000 | (next_rand() & 32'h1E0) | (next_rand() & 32'hD);
            if ((next_rand() & 32'h7) != 0) ptrd[1] = 1'b1;
            ga = page_8k ? {ptrd[31:7], va[17:13], 2'b00} : {ptrd[31:8], va[17:12], 2'b00};
            kind = int'(next_rand() % 5);
            leaf = 32'h0040_0000 | (next_rand() & 32'h0FF1C);
            ia   = 32'h0050_0000 | (next_rand() & 32'hFC);
            case (kind)
                0: leaf[1:0] = 2'b00;
                1: leaf[1:0] = 2'b01;
                2: leaf[1:0] = 2'b11;
                default: begin
                    mem[ia] = leaf | ((kind == 3) ? 32'h1 : 32'h0);
                    leaf    = ia | 32'h2;
                end
            endcase
            mem[ra] = rootd;
            mem[pa] = ptrd;
            mem[ga] = leaf;
            esel = int'(next_rand() % 10);
            case (esel)
                0: err_addr = ra;
                1: err_addr = pa;
                2: err_addr = ga;
                3: err_addr = ia;
                default: err_addr = 32'hFFFF_FFFF;
            endcase
            foreach (mem[k]) ref_mem[k] = mem[k];
            ref_walk(va, s, w, page_8k, er, einv, tag);
            run_walk(va, s, w, r, inv);
            chk(r == er, tag, "result descriptor", r, er);
            chk(inv == einv, tag, "invalid flag", 32'(inv), 32'(einv));
            compare_log(tag);
        end

        // R11: a request offered while busy is ignored
        clear_logs();
        mem.delete(); ref_mem.delete();
        err_addr = 32'hFFFF_FFFF;
        lat = 2; page_8k = 1'b0;
        sup_root = 32'h0010_0000;
        va = 32'h0246_8ACE;
        ra = {sup_root[31:9], va[31:25], 2'b00};
        mem[ra] = 32'h0020_000A;
        pa = {mem[ra][31:9], va[24:18], 2'b00};
        mem[pa] = 32'h0030_000A;
        ga = {32'h0030_000A >> 8, va[17:12], 2'b00};
        mem[ga] = 32'h0040_0009;
        foreach (mem[k]) ref_mem[k] = mem[k];
        ref_walk(va, 1'b1, 1'b0, 1'b0, er, einv, tag);
        @(negedge clk);
        req_addr = va; req_super = 1'b1; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'hFFFF_0000; req_super = 1'b0; req_write = 1'b1;
        chk(req_ready == 1'b0, "R11", "ready while busy", 32'(req_ready), 32'h0);
        begin
            int g2 = 0;
            while (!done && g2 < 200) begin @(negedge clk); g2++; end
        end
        req_valid = 1'b0;
        chk(res_desc == er, "R11", "result with ignored request", res_desc, er);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R11", "idle after ignored request", 32'(busy), 32'h0);
        compare_log("R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule